// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block produces the pin waveforms for one byte transfer at a time on an 8-bit asynchronous NAND flash bus. A controller above it hands over a single operation (command byte, address byte, data byte to write, or data byte to read) through a valid/ready request port. The block then steps through three timed phases: latch setup, strobe low, and hold. It signals completion with a one-clock `done` pulse. For a read, it also returns the byte it captured.

The byte class is carried only by the command-latch and address-latch levels. On writes, the flash captures the byte on the rising edge of write enable. The three phase lengths come from configuration inputs counted in system clocks. Each phase lasts its setting plus one clock, so a zero setting still gives a one-clock phase. The pad is split into an output word, an output enable and an input word. Chip enable simply follows an external select line. Command sequencing, busy polling and error correction belong to the layer above.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, `req_ready` is 1. `done`, `cle`, `ale` and `io_oe` are 0. `we_n` and `re_n` are 1. `io_out` reads 0 whenever `io_oe` is 0.
- R2: `ce_n` is at all times the inverse of `sel_i`.
- R3: A command operation (`req_op` = 0) holds `cle`=1 and `ale`=0 through all three phases. It drives `io_oe`=1 with the accepted byte on `io_out`.
- R4: An address operation (`req_op` = 1) holds `ale`=1 and `cle`=0 through all three phases. It drives the byte as in R3.
- R5: A data write (`req_op` = 2) keeps `cle` and `ale` at 0 and drives the byte as in R3.
- R6: The setup phase lasts `cfg_setup`+1 clocks, starting in the cycle after the accepting edge. The strobes stay high during it.
- R7: On a write, `we_n` is low for exactly `cfg_pulse`+1 clocks, and `re_n` stays high.
- R8: After the strobe rises, latch levels and driven data are held for `cfg_hold`+1 clocks. Then, in the next cycle, `done` is 1 for one clock and all pins return to the R1 idle levels.
- R9: A read (`req_op` = 3) keeps `cle`, `ale` and `io_oe` at 0. It holds `re_n` low for `cfg_pulse`+1 clocks with `we_n` high. `rd_data` equals `io_in` as sampled on the last clock of the `re_n` low phase, and is valid when `done` is 1.
- R10: `req_ready` is 0 from the cycle after acceptance until the `done` cycle. `req_valid` and the request fields are ignored while busy.
- R11: Zero settings for all three phase counts give a one-clock setup, strobe and hold.
- R12: A new request presented while `done` is 1 is accepted in that cycle, giving back-to-back operations with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Device select from the layer above |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request is taken |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte for command, address or write |
| cfg_setup | input | TW | Setup phase length minus one |
| cfg_pulse | input | TW | Strobe low length minus one |
| cfg_hold | input | TW | Hold phase length minus one |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Pad output data |
| io_oe | output | 1 | Pad output enable |
| io_in | input | 8 | Pad input data |

## Verification
Completion of one operation and acceptance of the next can land in the same cycle. The `done` pulse and `req_ready` are both high then, and a waiting request is taken at that edge. The stimulus table is run back to back to provoke this: each entry is presented in the `done` cycle of the entry before. Every clock of the following operation's setup, strobe and hold is compared against the expected pin levels, so any lost or delayed acceptance shows up as a phase-length mismatch. For reads, the input bus carries the correct byte only on the final strobe-low clock, which shows whether the capture happens at that clock.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } nfc_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } nfc_phase_e;
endpackage

// File: rtl/nfc_phase_timer.sv
module nfc_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R6: a loaded nonzero count keeps the phase open for the next clock
    p_load_blocks_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !zero_o);
endmodule

// File: rtl/nfc_pin_decode.sv
module nfc_pin_decode
    import nfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  nfc_phase_e     phase_i,
    input  nfc_op_e        op_i,
    input  logic [DW-1:0]  byte_i,
    output logic           cle_o,
    output logic           ale_o,
    output logic           we_n_o,
    output logic           re_n_o,
    output logic           oe_o,
    output logic [DW-1:0]  dout_o
);
    logic active;
    logic is_read;

    always_comb begin
        active  = (phase_i != PH_IDLE);
        is_read = (op_i == OP_RD);
        cle_o   = active && (op_i == OP_CMD);
        ale_o   = active && (op_i == OP_ADDR);
        oe_o    = active && !is_read;
        we_n_o  = !((phase_i == PH_STROBE) && !is_read);
        re_n_o  = !((phase_i == PH_STROBE) && is_read);
        dout_o  = oe_o ? byte_i : '0;
    end
endmodule

// File: rtl/nfc_rd_capture.sv
module nfc_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o
);
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = cap_i ? din_i : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout_o = data_q;
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nfc_pkg::*;
#(
    parameter int TW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_pulse,
    input  logic [TW-1:0] cfg_hold,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          ce_n,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] io_out,
    output logic          io_oe,
    input  logic [DW-1:0] io_in
);
    typedef struct packed {
        nfc_phase_e    phase;
        nfc_op_e       op;
        logic [DW-1:0] byte_v;
        logic          done;
    } seq_t;

    seq_t          s_d, s_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cap;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase  = PH_SETUP;
                    s_d.op     = nfc_op_e'(req_op);
                    s_d.byte_v = req_data;
                    tmr_load   = 1'b1;
                    tmr_val    = cfg_setup;
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    s_d.phase = PH_STROBE;
                    tmr_load  = 1'b1;
                    tmr_val   = cfg_pulse;
                end
            end
            PH_STROBE: begin
                if (tmr_zero) begin
                    s_d.phase = PH_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = cfg_hold;
                    cap       = (s_q.op == OP_RD);
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, op: OP_CMD, byte_v: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    nfc_phase_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    nfc_pin_decode #(.DW(DW)) u_pins (
        .phase_i (s_q.phase),
        .op_i    (s_q.op),
        .byte_i  (s_q.byte_v),
        .cle_o   (cle),
        .ale_o   (ale),
        .we_n_o  (we_n),
        .re_n_o  (re_n),
        .oe_o    (io_oe),
        .dout_o  (io_out)
    );

    nfc_rd_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .din_i  (io_in),
        .dout_o (rd_data)
    );

    assign req_ready = (s_q.phase == PH_IDLE);
    assign done      = s_q.done;
    assign ce_n      = !sel_i;

    // R3 R4: never both latch enables at once
    p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R9: the two strobes are never low together
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R9: the pad is released whenever the read strobe is low
    p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);
    // R8: latch levels and data unchanged across the write-strobe rise
    p_stable_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($stable(cle) && $stable(ale) && $stable(io_out) && io_oe));
    // R8: completion is a single-clock pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: an accepted request makes the block busy
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10: the captured byte only changes as a read strobe ends
    p_rd_data_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $rose(re_n));
endmodule

// File: tb/tb_nand_cycle_gen.sv
module tb_nand_cycle_gen;
    localparam int TW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_i = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [DW-1:0] req_data = '0;
    logic [TW-1:0] cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0;
    logic          done;
    logic [DW-1:0] rd_data;
    logic          ce_n, cle, ale, we_n, re_n, io_oe;
    logic [DW-1:0] io_out;
    logic [DW-1:0] io_in = '0;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    nand_cycle_gen #(.TW(TW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_data(req_data),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .done(done), .rd_data(rd_data),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // op[29:28] data[27:20] setup[19:16] pulse[15:12] hold[11:8] readbyte[7:0]
    localparam logic [29:0] VEC [0:6] = '{
        {2'd0, 8'h00, 4'd2,  4'd3,  4'd1,  8'h00},
        {2'd1, 8'h5A, 4'd1,  4'd2,  4'd2,  8'h00},
        {2'd2, 8'hC3, 4'd0,  4'd0,  4'd0,  8'h00},
        {2'd3, 8'h11, 4'd1,  4'd3,  4'd2,  8'h96},
        {2'd0, 8'h30, 4'd0,  4'd1,  4'd0,  8'h00},
        {2'd3, 8'h22, 4'd0,  4'd0,  4'd0,  8'h3C},
        {2'd2, 8'hFF, 4'd15, 4'd15, 4'd15, 8'h00}
    };

    function automatic logic [15:0] pins_now();
        return {ce_n, req_ready, done, cle, ale, we_n, re_n, io_oe, io_out};
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(logic [1:0] op, logic [7:0] data, logic [3:0] s,
                          logic [3:0] p, logic [3:0] h, logic [7:0] rb);
        int total;
        int strobe_last;
        bit rd;
        logic cl, al;
        rd          = (op == 2'd3);
        cl          = (op == 2'd0);
        al          = (op == 2'd1);
        total       = int'(s) + int'(p) + int'(h) + 3;
        strobe_last = int'(s) + int'(p) + 1;
        check("R12 ready before request", {15'd0, req_ready}, 16'd1);
        cfg_setup = s; cfg_pulse = p; cfg_hold = h;
        req_op = op; req_data = data; req_valid = 1'b1;
        io_in = ~rb;
        @(negedge clk);
        // R10: keep a conflicting request asserted while busy
        req_op = op ^ 2'd1;
        req_data = ~data;
        for (int i = 0; i < total; i++) begin
            bit in_strobe;
            logic [15:0] exp;
            string tag;
            in_strobe = (i > int'(s)) && (i <= strobe_last);
            if (i == total - 1) req_valid = 1'b0;
            io_in = (i == strobe_last) ? rb : ~rb;
            exp = {1'b0, 1'b0, 1'b0, cl, al,
                   !(in_strobe && !rd), !(in_strobe && rd), !rd,
                   rd ? 8'h00 : data};
            if (i <= int'(s))    tag = "R6 R3 R4 R5 R10 setup";
            else if (in_strobe)  tag = rd ? "R9 R11 strobe" : "R7 R11 strobe";
            else                 tag = "R8 hold";
            check(tag, pins_now(), exp);
            @(negedge clk);
        end
        check("R8 done cycle", pins_now(), {1'b0, 1'b1, 1'b1, 5'b00110, 8'h00});
        if (rd) check("R9 read byte", {8'h00, rd_data}, {8'h00, rb});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state, R2 with select low
        check("R1 R2 reset", pins_now(), {1'b1, 1'b1, 1'b0, 5'b00110, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pins_now(), {1'b1, 1'b1, 1'b0, 5'b00110, 8'h00});
        sel_i = 1'b1;
        #1;
        check("R2 select high", {15'd0, ce_n}, 16'd0);
        @(negedge clk);
        for (int v = 0; v < 7; v++) begin
            run_op(VEC[v][29:28], VEC[v][27:20], VEC[v][19:16],
                   VEC[v][15:12], VEC[v][11:8], VEC[v][7:0]);
        end
        // R10: nothing started after the last done with valid low
        @(negedge clk);
        check("R10 idle after done", pins_now(), {1'b0, 1'b1, 1'b0, 5'b00110, 8'h00});
        check("R9 read byte kept", {8'h00, rd_data}, 16'h003C);
        sel_i = 1'b0;
        #1;
        check("R2 select low", {15'd0, ce_n}, 16'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule